// File: doc/BRIEF.md
# Repeated-Addition Sequential Multiplier

This block multiplies two unsigned operands of `WIDTH` bits into a product of `2*WIDTH` bits. It does this by adding the multiplicand into an accumulator once for every unit of the multiplier's value. The multiplier value counts down to zero in a down-counter. The multiplicand is zero-extended to the product width before each add. A two-state controller starts on a `go` pulse and raises `done` when the count is exhausted.

The number of add cycles equals the numeric value of the multiplier, not its bit count. Latency therefore depends on the data. An operation started with multiplier value M completes M+1 clock edges after the edge that accepted `go`. The critical path is the register clock-to-output time, plus one `2*WIDTH`-bit add, plus setup.

Top module: `rep_add_mul`

## Requirements
- R1: While reset (`rst_n` low) is applied at a clock edge, `product` becomes zero and `done` becomes 0, and the block waits idle for `go`.
- R2: The edge that samples `go` high while idle has three effects. It clears `product` to zero. It captures both operands. It drops `done` to 0.
- R3: On every running edge where the remaining count is non-zero, `product` grows by exactly the captured multiplicand, zero-extended, and the count falls by one. For multiplicand 5 and multiplier 3, the product after successive edges is 0, 5, 10 and 15.
- R4: `done` rises on the first running edge that finds the count at zero. This is M+1 edges after the start edge for multiplier value M. At that point `product` equals the unsigned product of the captured operands.
- R5: A multiplier of zero completes one edge after the start edge. It performs no add, and `product` stays zero.
- R6: A `go` pulse while running is ignored, and so are operand changes after the start edge. Neither affects the result or the latency.
- R7: After completion, `done` stays 1 and `product` holds its value until the next `go`, whatever the operand inputs do.
- R8: With both operands at all ones, the result is (2^WIDTH-1)^2. This is the worst case, which takes 2^WIDTH edges after the start edge, and no bit of the product is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| go | input | 1 | Start request, accepted only while idle |
| mcand | input | WIDTH | Multiplicand, sampled at start |
| mplier | input | WIDTH | Multiplier, sampled at start |
| product | output | 2*WIDTH | Accumulated product |
| done | output | 1 | High from completion until the next accepted `go` |

## Verification
The bound checker watches four things on every cycle. It checks that each running step adds exactly the captured multiplicand and decrements the count by one. It checks that an accepted start clears the product and loads the count. It checks that `done` only appears with a zero count, and that `done` and the product hold still while idle. The bench scenarios cover what the cycle checks cannot reach. These are the data-dependent latency, the final product values including the zero and all-ones multipliers, and the insensitivity to a second `go` and to operand changes during a run.

// File: rtl/rep_add_mul_pkg.sv
// Package: shared types for the repeated-addition multiplier.
// Assumes: nothing beyond a two-state controller.
package rep_add_mul_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mul_state_t;
endpackage

// File: rtl/ram_down_counter.sv
// Module: loadable down-counter holding the remaining add count.
// Assumes: load has priority over decrement; the controller never
// asserts decrement when the count is zero.
module ram_down_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] count,
    output logic             is_zero
);
    // Count register: reset, load or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (dec)
            count <= count - WIDTH'(1);
    end

    // Zero detect for the controller.
    always_comb is_zero = (count == '0);
endmodule

// File: rtl/ram_accumulator.sv
// Module: multiplicand capture register, 2W-bit adder and product register.
// Assumes: clear has priority over accumulate; capture coincides with clear.
module ram_accumulator #(
    parameter int WIDTH = 8,
    localparam int PW = 2 * WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             clear,
    input  logic             accum,
    input  logic [WIDTH-1:0] mcand_in,
    output logic [WIDTH-1:0] mcand_q,
    output logic [PW-1:0]    prod_q
);
    logic [PW-1:0] sum;

    // Hold the multiplicand for the whole run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mcand_q <= '0;
        else if (capture)
            mcand_q <= mcand_in;
    end

    // Adder: product plus zero-extended multiplicand.
    always_comb sum = prod_q + {{WIDTH{1'b0}}, mcand_q};

    // Product register: clear or load the sum.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prod_q <= '0;
        else if (clear)
            prod_q <= '0;
        else if (accum)
            prod_q <= sum;
    end
endmodule

// File: rtl/ram_ctrl_fsm.sv
// Module: two-state controller sequencing start, add steps and completion.
// Assumes: go is sampled only in idle; the counter reports zero combinationally.
module ram_ctrl_fsm
    import rep_add_mul_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic cnt_zero,
    output logic start,
    output logic step,
    output logic busy,
    output logic done
);
    mul_state_t state_q, state_d;
    logic       finish;

    // Decode controls from the current state.
    always_comb begin
        start  = (state_q == ST_IDLE) && go;
        step   = (state_q == ST_RUN) && !cnt_zero;
        finish = (state_q == ST_RUN) && cnt_zero;
        busy   = (state_q == ST_RUN);
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        if (start)
            state_d = ST_RUN;
        else if (finish)
            state_d = ST_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Done flag: set at finish, cleared at the next accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else if (start)
            done <= 1'b0;
        else if (finish)
            done <= 1'b1;
    end
endmodule

// File: rtl/rep_add_mul.sv
// Module: top level of the repeated-addition multiplier.
// Assumes: unsigned operands; latency is the multiplier value plus one edge.
module rep_add_mul #(
    parameter int WIDTH = 8,
    localparam int PW = 2 * WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [WIDTH-1:0] mcand,
    input  logic [WIDTH-1:0] mplier,
    output logic [PW-1:0]    product,
    output logic             done
);
    logic             start, step, busy, cnt_zero;
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] mcand_q;

    ram_ctrl_fsm u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .cnt_zero (cnt_zero),
        .start    (start),
        .step     (step),
        .busy     (busy),
        .done     (done)
    );

    ram_down_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .dec      (step),
        .load_val (mplier),
        .count    (cnt_q),
        .is_zero  (cnt_zero)
    );

    ram_accumulator #(.WIDTH(WIDTH)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (start),
        .clear    (start),
        .accum    (step),
        .mcand_in (mcand),
        .mcand_q  (mcand_q),
        .prod_q   (product)
    );
endmodule

// File: rtl/rep_add_mul_chk.sv
// Module: cycle-level property checker, bound into rep_add_mul.
// Assumes: sees the top ports plus the counter and captured multiplicand.
module rep_add_mul_chk #(
    parameter int WIDTH = 8,
    localparam int PW = 2 * WIDTH
) (
    input logic             clk,
    input logic             rst_n,
    input logic             go,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] mplier,
    input logic [WIDTH-1:0] cnt_q,
    input logic [WIDTH-1:0] mcand_q,
    input logic [PW-1:0]    product
);
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && go) |=> (product == '0 && cnt_q == $past(mplier) && !done && busy)); // R2
    AST_STEP_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != '0) |=> (product == $past(product) + {{WIDTH{1'b0}}, $past(mcand_q)})); // R3
    AST_STEP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - WIDTH'(1))); // R3
    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt_q == '0 && !busy)); // R4
    AST_RUN_IGNORES_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != '0) |=> (busy && !done)); // R6
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !go) |=> (done && $stable(product))); // R7
endmodule

bind rep_add_mul rep_add_mul_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .busy    (busy),
    .done    (done),
    .mplier  (mplier),
    .cnt_q   (cnt_q),
    .mcand_q (mcand_q),
    .product (product)
);

// File: tb/tb_rep_add_mul.sv
module tb_rep_add_mul;
    localparam int W  = 8;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          go = 1'b0;
    logic [W-1:0]  mcand = '0;
    logic [W-1:0]  mplier = '0;
    logic [PW-1:0] product;
    logic          done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    rep_add_mul #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .go(go), .mcand(mcand),
        .mplier(mplier), .product(product), .done(done)
    );

    always #2 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive go for one edge; returns at the negedge after the start edge.
    task automatic start_op(input logic [W-1:0] mc, input logic [W-1:0] mp);
        @(negedge clk);
        go = 1'b1; mcand = mc; mplier = mp;
        @(negedge clk);
        go = 1'b0;
    endtask

    // Count edges after the start edge until done appears.
    task automatic wait_done(output int edges);
        edges = 0;
        while (done !== 1'b1 && edges < 2000) begin
            @(negedge clk);
            edges++;
        end
    endtask

    task automatic t_reset();
        chk("R1 product after reset", product, '0);
        chk("R1 done after reset", PW'(done), '0);
    endtask

    task automatic t_sequence();
        start_op(8'd5, 8'd3);
        chk("R2 product cleared at start", product, '0);
        @(negedge clk); chk("R3 step 1", product, 16'd5);
        @(negedge clk); chk("R3 step 2", product, 16'd10);
        @(negedge clk); chk("R3 step 3", product, 16'd15);
        chk("R3 not done yet", PW'(done), '0);
        @(negedge clk); chk("R4 done after M+1 edges", PW'(done), 16'd1);
        chk("R4 5x3 result", product, 16'd15);
    endtask

    task automatic t_product(input logic [W-1:0] mc, input logic [W-1:0] mp, input string tag);
        int e;
        start_op(mc, mp);
        wait_done(e);
        chk({tag, " latency"}, PW'(e), PW'(mp) + 16'd1);
        chk({tag, " result"}, product, PW'(mc) * PW'(mp));
    endtask

    task automatic t_zero();
        int e;
        start_op(8'd200, 8'd0);
        wait_done(e);
        chk("R5 zero multiplier latency", PW'(e), 16'd1);
        chk("R5 zero multiplier result", product, '0);
    endtask

    task automatic t_ignore_go();
        int e;
        start_op(8'd7, 8'd10);
        @(negedge clk);
        go = 1'b1; mcand = 8'd99; mplier = 8'd2;
        @(negedge clk);
        go = 1'b0; mcand = 8'd33; mplier = 8'd44;
        e = 2;
        while (done !== 1'b1 && e < 2000) begin
            @(negedge clk);
            e++;
        end
        chk("R6 latency with extra go", PW'(e), 16'd11);
        chk("R6 result with extra go", product, 16'd70);
    endtask

    task automatic t_hold();
        logic [PW-1:0] held;
        held = product;
        mcand = 8'd17; mplier = 8'd9;
        repeat (6) @(negedge clk);
        chk("R7 done held", PW'(done), 16'd1);
        chk("R7 product held", product, held);
        start_op(8'd2, 8'd2);
        chk("R2 done dropped at start", PW'(done), '0);
        chk("R2 product cleared on restart", product, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_sequence();
        t_product(8'd13, 8'd11, "R4 13x11");
        t_product(8'd1, 8'd1, "R4 1x1");
        t_zero();
        t_ignore_go();
        t_hold();
        begin
            int e;
            wait_done(e);
        end
        t_product(8'd255, 8'd255, "R8 all ones");
        t_product(8'd0, 8'd40, "R4 zero multiplicand");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule